// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns one interrupt request into the set of agents that should receive it. A request carries a destination byte, a physical/logical addressing bit, a two-bit shorthand code, the index of the sending agent and a three-bit delivery mode. Each agent has a row in a small table. The row holds a present bit, a physical ID byte, a logical destination byte and a logical model nibble. From the request and the table the resolver builds a bitmask with one bit per agent index. It applies the shorthand override and the physical, flat-logical or cluster-logical matching. For lowest-priority delivery it then keeps only one target.

The result is registered. Mask, valid strobe and an empty-mask flag appear one cycle after the request strobe. One INIT variant (level 0, trigger 1) interrupts no agent. Instead it makes each targeted agent load its physical ID into an arbitration-ID register that the block holds, and it is marked by a separate output flag. Delivery of the vector to the targets, and any priority-based arbitration, are left to the logic around this block.

Top module: `irq_dest_resolver`

## Requirements
- R1: Shorthand code 1 selects only the agent whose index equals `req_sender`, if that agent is present.
- R2: Shorthand code 2 selects every present agent. The destination byte and the addressing bit are ignored.
- R3: Shorthand code 3 selects every present agent except the sender.
- R4: With shorthand code 0 and `req_logical`=0, a destination of 0xFF selects every present agent.
- R5: With shorthand code 0 and `req_logical`=0, any other destination selects each present agent whose physical ID equals it. If no agent matches, nothing is selected.
- R6: With shorthand 0 and `req_logical`=1, an agent whose model nibble is 0xF matches when destination AND its logical byte is nonzero.
- R7: With shorthand 0 and `req_logical`=1, an agent whose model nibble is 0x0 matches under two conditions. The upper nibbles of the destination and its logical byte must be equal. The AND of their lower nibbles must also be nonzero.
- R8: In logical mode an agent whose model nibble is neither 0xF nor 0x0 never matches.
- R9: Delivery mode 3'b001 (lowest priority) reduces the mask to its lowest-numbered set bit.
- R10: Delivery mode 3'b101 with `req_level`=0 and `req_trig`=1 raises `out_arb_sync`. In the same edge it copies each targeted agent's physical ID into that agent's byte of `arb_id`. Any other request leaves `arb_id` unchanged and `out_arb_sync` low. `arb_id` resets to zero.
- R11: `out_valid` pulses in the cycle after each request. `out_mask` never has a bit set for an agent whose present bit was low at the request.
- R12: `out_none` is 1 with `out_valid` exactly when the resolved mask is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_shorthand | input | 2 | 0 decode, 1 self, 2 all, 3 all but self |
| req_sender | input | SEL_W | Index of the sending agent |
| req_mode | input | 3 | Delivery mode (3'b001 lowest priority, 3'b101 INIT) |
| req_level | input | 1 | Level bit of the command |
| req_trig | input | 1 | Trigger bit of the command |
| agent_present | input | AGENTS | Present bit per agent |
| agent_phys_id | input | AGENTS*8 | Physical ID byte per agent |
| agent_log_dest | input | AGENTS*8 | Logical destination byte per agent |
| agent_model | input | AGENTS*4 | Logical model nibble per agent |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_mask | output | AGENTS | Resolved target mask |
| out_none | output | 1 | Resolved mask is empty |
| out_arb_sync | output | 1 | Result was an arbitration-ID sync, not an interrupt |
| arb_id | output | AGENTS*8 | Arbitration ID byte per agent |

## Verification
The assertions check several rules on every cycle. The result strobe must follow each request by exactly one cycle. No absent agent may appear in the mask. The all-but-self shorthand must never include the sender, and the self shorthand must give exactly the sender's present bit. A lowest-priority result must carry at most one bit. Each agent named by an arbitration sync must then hold its own physical ID. The exact matching rules are shown only by the bench's scenarios. These are the 0xFF broadcast, the ID miss, flat versus cluster nibble comparison and the silence of other model values. The bench also shows that lowest-priority reduction picks the lowest index and that a non-sync INIT leaves the arbitration IDs alone.

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver #(
  parameter int AGENTS = 8,
  parameter int DEST_W = 8,
  parameter int MODEL_W = 4,
  localparam int SEL_W = (AGENTS > 1) ? $clog2(AGENTS) : 1,
  localparam int HALF = DEST_W / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [DEST_W-1:0]         req_dest,
  input  logic                      req_logical,
  input  logic [1:0]                req_shorthand,
  input  logic [SEL_W-1:0]          req_sender,
  input  logic [2:0]                req_mode,
  input  logic                      req_level,
  input  logic                      req_trig,
  input  logic [AGENTS-1:0]         agent_present,
  input  logic [AGENTS*DEST_W-1:0]  agent_phys_id,
  input  logic [AGENTS*DEST_W-1:0]  agent_log_dest,
  input  logic [AGENTS*MODEL_W-1:0] agent_model,
  output logic                      out_valid,
  output logic [AGENTS-1:0]         out_mask,
  output logic                      out_none,
  output logic                      out_arb_sync,
  output logic [AGENTS*DEST_W-1:0]  arb_id
);

  localparam logic [2:0] MODE_LOWEST = 3'b001;
  localparam logic [2:0] MODE_INIT   = 3'b101;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = '1;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = '0;

  logic [AGENTS-1:0] dest_hit, self_bit, picked, reachable, final_mask;
  logic              arb_sync;

  assign self_bit = AGENTS'(1) << req_sender;
  assign arb_sync = (req_mode == MODE_INIT) && !req_level && req_trig;

  always_comb begin
    dest_hit = '0;
    for (int i = 0; i < AGENTS; i++) begin
      logic [DEST_W-1:0]  pid, ldst;
      logic [MODEL_W-1:0] mdl;
      pid  = agent_phys_id[i*DEST_W +: DEST_W];
      ldst = agent_log_dest[i*DEST_W +: DEST_W];
      mdl  = agent_model[i*MODEL_W +: MODEL_W];
      if (!req_logical)
        dest_hit[i] = (req_dest == '1) || (pid == req_dest);
      else if (mdl == MODEL_FLAT)
        dest_hit[i] = |(ldst & req_dest);
      else if (mdl == MODEL_CLUSTER)
        dest_hit[i] = (ldst[DEST_W-1:HALF] == req_dest[DEST_W-1:HALF]) &&
                      |(ldst[HALF-1:0] & req_dest[HALF-1:0]);
    end
  end

  always_comb begin
    case (req_shorthand)
      2'd0:    picked = dest_hit;
      2'd1:    picked = self_bit;
      2'd2:    picked = '1;
      default: picked = ~self_bit;
    endcase
  end

  assign reachable  = picked & agent_present;
  assign final_mask = (req_mode == MODE_LOWEST) ? (reachable & (~reachable + AGENTS'(1)))
                                                : reachable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_mask     <= '0;
      out_none     <= 1'b0;
      out_arb_sync <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_mask     <= final_mask;
        out_none     <= (final_mask == '0);
        out_arb_sync <= arb_sync;
      end
    end
  end

  for (genvar g = 0; g < AGENTS; g++) begin : g_arb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        arb_id[g*DEST_W +: DEST_W] <= '0;
      else if (req_valid && arb_sync && final_mask[g])
        arb_id[g*DEST_W +: DEST_W] <= agent_phys_id[g*DEST_W +: DEST_W];
    end

    assert_arb_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_arb_sync && out_mask[g]) |->
        (arb_id[g*DEST_W +: DEST_W] == $past(agent_phys_id[g*DEST_W +: DEST_W])));
  end

  assert_strobe_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(req_valid));

  assert_absent_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & ~$past(agent_present)) == '0));

  assert_excl_sender_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_shorthand) == 2'd3) |-> ((out_mask & $past(self_bit)) == '0));

  assert_self_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_shorthand) == 2'd1) |->
      (out_mask == ($past(self_bit) & $past(agent_present))));

  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_mode) == MODE_LOWEST) |-> $onehot0(out_mask));

endmodule

// File: tb/sim_irq_dest_resolver.sv
module sim_irq_dest_resolver;
  localparam int N = 8;

  typedef struct packed {
    logic [7:0] dest;
    logic       logical;
    logic [1:0] sh;
    logic [2:0] sender;
    logic [2:0] mode;
    logic       level;
    logic       trig;
    logic [7:0] mask;
    logic       none;
    logic       sync;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{8'h12, 1'b0, 2'd0, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0000_0100, 1'b0, 1'b0}, // R5
    '{8'h17, 1'b0, 2'd0, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0000_0000, 1'b1, 1'b0}, // R11 absent
    '{8'h55, 1'b0, 2'd0, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0000_0000, 1'b1, 1'b0}, // R5 R12
    '{8'hFF, 1'b0, 2'd0, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0111_1111, 1'b0, 1'b0}, // R4
    '{8'h12, 1'b0, 2'd1, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0000_1000, 1'b0, 1'b0}, // R1
    '{8'h55, 1'b1, 2'd2, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0111_1111, 1'b0, 1'b0}, // R2
    '{8'h12, 1'b0, 2'd3, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0111_0111, 1'b0, 1'b0}, // R3
    '{8'h06, 1'b1, 2'd0, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0000_0110, 1'b0, 1'b0}, // R6
    '{8'h23, 1'b1, 2'd0, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0011_0011, 1'b0, 1'b0}, // R7
    '{8'h31, 1'b1, 2'd0, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0000_0001, 1'b0, 1'b0}, // R7
    '{8'hF0, 1'b1, 2'd0, 3'd3, 3'b000, 1'b1, 1'b0, 8'b0000_0000, 1'b1, 1'b0}, // R8
    '{8'hFF, 1'b0, 2'd0, 3'd3, 3'b001, 1'b1, 1'b0, 8'b0000_0001, 1'b0, 1'b0}, // R9
    '{8'h06, 1'b1, 2'd0, 3'd3, 3'b001, 1'b1, 1'b0, 8'b0000_0010, 1'b0, 1'b0}, // R9
    '{8'h00, 1'b0, 2'd3, 3'd0, 3'b001, 1'b1, 1'b0, 8'b0000_0010, 1'b0, 1'b0}, // R9
    '{8'h15, 1'b0, 2'd0, 3'd3, 3'b101, 1'b0, 1'b1, 8'b0010_0000, 1'b0, 1'b1}, // R10
    '{8'h13, 1'b0, 2'd0, 3'd3, 3'b101, 1'b1, 1'b1, 8'b0000_1000, 1'b0, 1'b0}  // R10
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [7:0]   req_dest = '0;
  logic         req_logical = 1'b0;
  logic [1:0]   req_shorthand = '0;
  logic [2:0]   req_sender = '0;
  logic [2:0]   req_mode = '0;
  logic         req_level = 1'b0;
  logic         req_trig = 1'b0;
  logic [N-1:0] agent_present;
  logic [N*8-1:0] agent_phys_id, agent_log_dest;
  logic [N*4-1:0] agent_model;
  logic         out_valid, out_none, out_arb_sync;
  logic [N-1:0] out_mask;
  logic [N*8-1:0] arb_id;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_dest_resolver #(.AGENTS(N)) u0 (
    .clk, .rst_n, .req_valid, .req_dest, .req_logical, .req_shorthand, .req_sender,
    .req_mode, .req_level, .req_trig, .agent_present, .agent_phys_id, .agent_log_dest,
    .agent_model, .out_valid, .out_mask, .out_none, .out_arb_sync, .arb_id
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    agent_present = 8'b0111_1111;
    for (int i = 0; i < N; i++) agent_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
    agent_log_dest = {8'hFF, 8'hFF, 8'h22, 8'h21, 8'h08, 8'h04, 8'h02, 8'h01};
    agent_model    = {4'hF, 4'h5, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset arb_id", 64'(arb_id), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      req_valid = 1'b1;
      req_dest = TBL[v].dest; req_logical = TBL[v].logical; req_shorthand = TBL[v].sh;
      req_sender = TBL[v].sender; req_mode = TBL[v].mode;
      req_level = TBL[v].level; req_trig = TBL[v].trig;
      @(negedge clk);
      check($sformatf("R11 valid v%0d", v), 64'(out_valid), 64'd1);
      check($sformatf("R1-R9 mask v%0d (R1 R2 R3 R4 R5 R6 R7 R8 R9)", v), 64'(out_mask), 64'(TBL[v].mask));
      check($sformatf("R12 none v%0d", v), 64'(out_none), 64'(TBL[v].none));
      check($sformatf("R10 sync v%0d", v), 64'(out_arb_sync), 64'(TBL[v].sync));
      if (v == 14) check("R10 arb_id after sync", 64'(arb_id), 64'(8'h15) << 40);
      if (v == 15) check("R10 arb_id untouched by non-sync INIT", 64'(arb_id), 64'(8'h15) << 40);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R11 no request no strobe", 64'(out_valid), 64'd0);
    // R1: sender absent gives empty mask
    req_valid = 1'b1; req_shorthand = 2'd1; req_sender = 3'd7; req_mode = 3'b000;
    @(negedge clk);
    check("R1 absent sender", 64'(out_mask), 64'd0);
    check("R12 absent sender none", 64'(out_none), 64'd1);
    // R10: broadcast sync loads every present agent
    req_shorthand = 2'd2; req_mode = 3'b101; req_level = 1'b0; req_trig = 1'b1;
    @(negedge clk);
    check("R10 broadcast sync", 64'(arb_id), 64'h0016_1514_1312_1110);
    req_valid = 1'b0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule